// File: doc/BRIEF.md
# SPI Slave Byte Port with Write-Collision Guard

This block is the slave end of a byte-wide SPI link. While the external master toggles the serial clock, the block shifts a byte out on MISO and a byte in from MOSI at the same time, most significant bit first. The three serial inputs and the select line are re-timed into the local system clock. That clock runs at least four times faster than SCK, so all serial behaviour is decided on edges detected in the system clock domain. Two control bits pick one of the four clock modes. The polarity bit sets which SCK level is idle. The phase bit decides whether data is captured on the first or the second edge of each bit.

On the CPU side the block has a transmit data register and a receive buffer. There are also a transfer-complete flag, which is cleared by reading the receive buffer, and a write-collision flag, which is cleared by a status read. While a byte is in flight, the transmit register is locked. A write that arrives during that window is dropped and raises the collision flag. An output-disable bit lets the integrator release the MISO pin; here that means the output-enable port goes low.

Top module: `spi_slave_guard`

## Requirements
- R1: After reset, `done_flag`, `coll_flag` and `miso_oe` are 0 and `rx_data` is 0x00.
- R2: After eight capture edges, the eight MOSI bits (first bit in position 7) appear on `rx_data` and `done_flag` is set. A one-cycle `data_rd` pulse clears `done_flag`.
- R3: With `cfg_cpha`=0, the leading SCK edge captures MOSI. The leading edge is rising when `cfg_cpol`=0 and falling when `cfg_cpol`=1. MISO changes on the trailing edge. Bit 7 of the transmit register is on MISO within three system cycles after select falls.
- R4: With `cfg_cpha`=1, MISO changes on the leading edge and MOSI is captured on the trailing edge. Select may stay low across several bytes. Between bytes a CPU write is accepted with no collision, and its value is the next byte shifted out.
- R5: With `cfg_cpha`=0, once a byte is complete, further SCK edges are ignored until select rises and falls again. `rx_data` keeps the completed byte.
- R6: While the transmit register is locked, a `data_wr` pulse leaves it unchanged and sets `coll_flag`. The register is locked when `cfg_cpha`=0 and select is low, or when `cfg_cpha`=1 and a byte is in flight. The byte then shifted out is the old value.
- R7: A one-cycle `stat_rd` pulse clears `coll_flag`.
- R8: `miso_oe` is 1 only when the block is enabled, select is low and `cfg_miso_off` is 0.
- R9: If select rises before the eighth capture, the partial byte is discarded. `done_flag` stays 0, `rx_data` is unchanged, and the next full byte is received correctly.
- R10: Clearing `cfg_en` resets the bit counter and the shift state. After re-enable, no capture happens until select falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Block enable; 0 holds serial state in reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| cfg_miso_off | input | 1 | 1 releases the MISO pin |
| data_wr | input | 1 | CPU write strobe for the transmit register |
| data_wdata | input | DW | CPU write data |
| data_rd | input | 1 | CPU read strobe of the receive buffer; clears done flag |
| stat_rd | input | 1 | CPU status read strobe; clears collision flag |
| sck | input | 1 | Serial clock from master |
| mosi | input | 1 | Serial data from master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | MISO driver enable |
| rx_data | output | DW | Receive buffer |
| done_flag | output | 1 | Byte received |
| coll_flag | output | 1 | Write collision seen |

## Verification
The bench targets the lock window. A design that checks select alone would flag a legal between-byte write in phase-1 mode. A design that does not check at all would let a mid-byte write corrupt the byte on the wire. Select is deliberately left low after a phase-0 byte and the clock keeps running; a design that keeps counting would post a phantom byte. Select is also raised after four bits, and the enable bit is dropped with select still low. A design that keeps partial state would then misalign every later byte by the leftover bit count.

// File: rtl/spi_guard_pkg.sv
// Shared types and edge classification for the SPI slave guard block.
package spi_guard_pkg;

    // Meaning of one detected SCK transition in the current mode.
    typedef struct packed {
        logic cap;  // sample MOSI on this edge
        logic shf;  // advance MISO on this edge
    } spi_edge_t;

    // Map a raw rise/fall of SCK to capture/shift, given polarity and phase.
    function automatic spi_edge_t classify(input logic cpol, input logic cpha,
                                           input logic rise, input logic fall);
        spi_edge_t e;
        logic      lead;
        logic      trail;
        lead  = cpol ? fall : rise;
        trail = cpol ? rise : fall;
        e.cap = cpha ? trail : lead;
        e.shf = cpha ? lead  : trail;
        return e;
    endfunction

endpackage

// File: rtl/spi_guard_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 2; each bit is re-timed independently.
module spi_guard_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw bundle through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_guard_core.sv
// Serial engine: detects SCK/select edges on synchronized inputs,
// counts bits, captures MOSI and drives the MISO bit.
// Assumes synchronized inputs and a system clock >= 4x SCK.
module spi_guard_core
    import spi_guard_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          ss_s,
    input  logic [DW-1:0] tx_word,
    output logic          miso_bit,
    output logic          byte_done,
    output logic [DW-1:0] rx_word,
    output logic          guard,
    output logic [CW-1:0] bit_cnt
);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic          sck_d, ss_d;
    logic          armed, mid;
    logic [CW-1:0] cnt;
    logic [DW-1:0] tx_sh;
    logic [DW-2:0] rx_sh;
    logic          miso_q;
    logic          rise, fall, ss_fall, ss_rise, cap_ok, shf_ok, last;
    spi_edge_t     e;

    // Decode edges and qualify them with the byte state.
    always_comb begin
        rise    = sck_s & ~sck_d;
        fall    = ~sck_s & sck_d;
        e       = classify(cpol, cpha, rise, fall);
        ss_fall = ss_d & ~ss_s;
        ss_rise = ~ss_d & ss_s;
        cap_ok  = e.cap & armed & ~ss_s;
        shf_ok  = e.shf & armed & ~ss_s;
        last    = (cnt == LAST);
    end

    // Keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            ss_d  <= ss_s;
        end
    end

    // Bit counter, shifters and arming state.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            armed  <= 1'b0;
            mid    <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (ss_rise) begin
            cnt   <= '0;
            armed <= 1'b0;
            mid   <= 1'b0;
        end else if (ss_fall) begin
            cnt   <= '0;
            armed <= 1'b1;
            mid   <= 1'b0;
            if (!cpha) begin
                miso_q <= tx_word[DW-1];
                tx_sh  <= tx_word << 1;
            end
        end else if (cap_ok) begin
            rx_sh <= {rx_sh[DW-3:0], mosi_s};
            cnt   <= last ? '0 : cnt + 1'b1;
            if (last) begin
                mid <= 1'b0;
                if (!cpha) armed <= 1'b0;
            end
        end else if (shf_ok) begin
            if (cpha && !mid) begin
                miso_q <= tx_word[DW-1];
                tx_sh  <= tx_word << 1;
                mid    <= 1'b1;
            end else begin
                miso_q <= tx_sh[DW-1];
                tx_sh  <= tx_sh << 1;
            end
        end
    end

    assign miso_bit  = miso_q;
    assign byte_done = cap_ok & last;
    assign rx_word   = {rx_sh, mosi_s};
    assign guard     = ~ss_s & (~cpha | mid);
    assign bit_cnt   = cnt;
endmodule

// File: rtl/spi_guard_regs.sv
// CPU-side registers: transmit word with lock, receive buffer, flags.
// Assumes strobes are single-cycle; a set and a clear in the same cycle resolve to set.
module spi_guard_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_data,
    input  logic          rd_stat,
    input  logic          guard,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_word,
    output logic [DW-1:0] data_reg,
    output logic [DW-1:0] rx_buf,
    output logic          done_flag,
    output logic          coll_flag,
    output logic          coll_set
);
    assign coll_set = wr & guard;

    // Transmit register: accept writes only outside the lock window.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_reg <= '0;
        else if (wr && !guard)     data_reg <= wdata;
    end

    // Receive buffer and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            done_flag <= 1'b0;
        end else if (byte_done) begin
            rx_buf    <= rx_word;
            done_flag <= 1'b1;
        end else if (rd_data) begin
            done_flag <= 1'b0;
        end
    end

    // Collision flag: set by a locked write, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)        coll_flag <= 1'b0;
        else if (coll_set) coll_flag <= 1'b1;
        else if (rd_stat)  coll_flag <= 1'b0;
    end
endmodule

// File: rtl/spi_slave_guard.sv
// Top of the SPI slave with write-collision guard.
// Assumes clk >= 4x SCK; MISO tri-state is realised by the integrator from miso_oe.
module spi_slave_guard #(
    parameter int DW       = 8,
    parameter int SYNC_STG = 2,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          cfg_miso_off,
    input  logic          data_wr,
    input  logic [DW-1:0] data_wdata,
    input  logic          data_rd,
    input  logic          stat_rd,
    input  logic          sck,
    input  logic          mosi,
    input  logic          ss_n,
    output logic          miso,
    output logic          miso_oe,
    output logic [DW-1:0] rx_data,
    output logic          done_flag,
    output logic          coll_flag
);
    logic [2:0]    pins_s;
    logic          sck_s, mosi_s, ss_s;
    logic [DW-1:0] data_reg, rx_word;
    logic          byte_done, guard, coll_set;
    logic [CW-1:0] bit_cnt;

    spi_guard_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sck, mosi, ss_n}), .q(pins_s)
    );
    assign {sck_s, mosi_s, ss_s} = pins_s;

    spi_guard_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .cpol(cfg_cpol), .cpha(cfg_cpha),
        .sck_s(sck_s), .mosi_s(mosi_s), .ss_s(ss_s), .tx_word(data_reg),
        .miso_bit(miso), .byte_done(byte_done), .rx_word(rx_word),
        .guard(guard), .bit_cnt(bit_cnt)
    );

    spi_guard_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(data_wdata),
        .rd_data(data_rd), .rd_stat(stat_rd), .guard(guard),
        .byte_done(byte_done), .rx_word(rx_word), .data_reg(data_reg),
        .rx_buf(rx_data), .done_flag(done_flag), .coll_flag(coll_flag),
        .coll_set(coll_set)
    );

    assign miso_oe = cfg_en & ~cfg_miso_off & ~ss_s;
endmodule

// File: rtl/spi_guard_chk.sv
// Property checker for spi_slave_guard, attached by bind below.
module spi_guard_chk #(
    parameter int DW = 8,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_en,
    input logic          cfg_miso_off,
    input logic          miso_oe,
    input logic          ss_s,
    input logic          data_wr,
    input logic          guard,
    input logic [DW-1:0] data_reg,
    input logic          byte_done,
    input logic          done_flag,
    input logic          data_rd,
    input logic          stat_rd,
    input logic          coll_flag,
    input logic          coll_set,
    input logic [CW-1:0] bit_cnt
);
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && guard) |=> $stable(data_reg));
    assert_coll_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && guard) |=> coll_flag);
    assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && data_rd && !byte_done) |=> !done_flag);
    assert_done_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(byte_done));
    assert_coll_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_flag && stat_rd && !coll_set) |=> !coll_flag);
    assert_disable_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (bit_cnt == '0));
    assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s || !cfg_en || cfg_miso_off) |-> !miso_oe);
    assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> (bit_cnt == '0));
endmodule

bind spi_slave_guard spi_guard_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_miso_off(cfg_miso_off),
    .miso_oe(miso_oe), .ss_s(ss_s), .data_wr(data_wr), .guard(guard),
    .data_reg(data_reg), .byte_done(byte_done), .done_flag(done_flag),
    .data_rd(data_rd), .stat_rd(stat_rd), .coll_flag(coll_flag),
    .coll_set(coll_set), .bit_cnt(bit_cnt)
);

// File: tb/sim_spi_slave_guard.sv
// Scoreboard bench: the transfer task queues expected receive bytes,
// and a monitor pops and compares them whenever done_flag rises.
module sim_spi_slave_guard;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_miso_off = 1'b0;
    logic       data_wr = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic       miso, miso_oe, done_flag, coll_flag;
    logic [7:0] rx_data;

    int         nvec = 0;
    int         nfail = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    spi_slave_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_miso_off(cfg_miso_off), .data_wr(data_wr),
        .data_wdata(data_wdata), .data_rd(data_rd), .stat_rd(stat_rd),
        .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe),
        .rx_data(rx_data), .done_flag(done_flag), .coll_flag(coll_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [7:0] d);
        data_wr = 1'b1; data_wdata = d;
        tick(1);
        data_wr = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cfg_en = 1'b0;
        tick(2);
        cfg_cpol = pol; cfg_cpha = pha; sck = pol;
        tick(4);
        cfg_en = 1'b1;
        tick(2);
    endtask

    // Master-side byte: optional select fall/rise, nbits clocks, MISO check when push=1.
    task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_miso, input int nbits,
                        input bit lower, input bit raise, input bit push, input string req);
        logic [7:0] got = '0;
        if (push) exp_q.push_back(mo);
        if (lower) begin ss_n = 1'b0; tick(HALF); end
        for (int i = 7; i > 7 - nbits; i--) begin
            if (!cfg_cpha) begin
                mosi = mo[i]; tick(HALF);
                got[i] = miso; sck = ~sck; tick(HALF);
                sck = ~sck;
            end else begin
                sck = ~sck; mosi = mo[i]; tick(HALF);
                got[i] = miso; sck = ~sck; tick(HALF);
            end
        end
        tick(HALF);
        if (raise) begin ss_n = 1'b1; tick(HALF); end
        if (push) chk(req, {24'd0, got}, {24'd0, exp_miso});
    endtask

    // Monitor: compare each completed byte against the scoreboard, then read it.
    initial begin
        forever begin
            @(negedge clk);
            if (done_flag) begin
                if (exp_q.size() == 0) begin
                    chk("R5_R9 unexpected byte", {24'd0, rx_data}, 32'hFFFF_FFFF);
                end else begin
                    chk("R2 rx byte", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
                end
                data_rd = 1'b1;
                @(negedge clk);
                data_rd = 1'b0;
            end
        end
    end

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk("R1 done", {31'd0, done_flag}, 0);
        chk("R1 coll", {31'd0, coll_flag}, 0);
        chk("R1 oe", {31'd0, miso_oe}, 0);
        chk("R1 rx", {24'd0, rx_data}, 0);

        // Mode cpol0/cpha0
        set_mode(1'b0, 1'b0);
        cpu_write(8'hA5);
        xfer(8'h3C, 8'hA5, 8, 1, 1, 1, "R3 mode0 miso");
        cpu_write(8'h7E);
        xfer(8'h81, 8'h7E, 8, 1, 1, 1, "R3 mode0 miso b2");
        chk("R2 done cleared", {31'd0, done_flag}, 0);

        // R8: output enable
        ss_n = 1'b0; tick(HALF);
        chk("R8 oe selected", {31'd0, miso_oe}, 1);
        cfg_miso_off = 1'b1; tick(2);
        chk("R8 oe disabled", {31'd0, miso_oe}, 0);
        cfg_miso_off = 1'b0; ss_n = 1'b1; tick(4);
        chk("R8 oe deselected", {31'd0, miso_oe}, 0);

        // Mode cpol0/cpha1, multi-byte with legal between-byte write (R4)
        set_mode(1'b0, 1'b1);
        cpu_write(8'h5A);
        xfer(8'hC3, 8'h5A, 8, 1, 0, 1, "R4 mode1 byte1");
        cpu_write(8'h96);
        chk("R4 no collision between bytes", {31'd0, coll_flag}, 0);
        xfer(8'h69, 8'h96, 8, 0, 1, 1, "R4 mode1 byte2");

        // Mode cpol1/cpha0 and cpol1/cpha1
        set_mode(1'b1, 1'b0);
        cpu_write(8'hF0);
        xfer(8'h0F, 8'hF0, 8, 1, 1, 1, "R3 mode2 miso");
        set_mode(1'b1, 1'b1);
        cpu_write(8'h11);
        xfer(8'hEE, 8'h11, 8, 1, 1, 1, "R4 mode3 miso");

        // R6/R7: collision while selected
        set_mode(1'b0, 1'b0);
        cpu_write(8'h22);
        ss_n = 1'b0; tick(HALF);
        cpu_write(8'h99);
        tick(2);
        chk("R6 coll set", {31'd0, coll_flag}, 1);
        xfer(8'h44, 8'h22, 8, 0, 1, 1, "R6 old byte kept");
        chk("R6 coll holds", {31'd0, coll_flag}, 1);
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0; tick(1);
        chk("R7 coll cleared", {31'd0, coll_flag}, 0);
        xfer(8'h00, 8'h22, 8, 1, 1, 1, "R6 register unchanged");

        // R5: extra clocks after a phase-0 byte with select held low
        xfer(8'hB7, 8'h22, 8, 1, 0, 1, "R5 first byte");
        xfer(8'h00, 8'h00, 8, 0, 1, 0, "R5 extra");
        tick(6);
        chk("R5 rx keeps byte", {24'd0, rx_data}, 32'hB7);

        // R9: partial byte discarded
        xfer(8'hF3, 8'h00, 4, 1, 1, 0, "R9 partial");
        tick(6);
        chk("R9 no done", {31'd0, done_flag}, 0);
        chk("R9 rx unchanged", {24'd0, rx_data}, 32'hB7);
        xfer(8'h6D, 8'h22, 8, 1, 1, 1, "R9 realigned");

        // R10: disable mid-byte with select held low
        xfer(8'hFF, 8'h00, 3, 1, 0, 0, "R10 partial");
        cfg_en = 1'b0; tick(2); cfg_en = 1'b1; tick(2);
        xfer(8'h55, 8'h00, 8, 0, 1, 0, "R10 no capture");
        tick(6);
        chk("R10 rx unchanged", {24'd0, rx_data}, 32'h6D);
        xfer(8'hA1, 8'h22, 8, 1, 1, 1, "R10 clean restart");

        tick(20);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule